// File: doc/BRIEF.md
# Legacy Interrupt Line Status and Enable Collector

This block gathers four level-sensitive legacy interrupt lines (A, B, C, D) from a bus segment and turns them into one interrupt toward a parent interrupt controller. Each line has a pending flag and an enable flag. Both live in one 32-bit control word that software reads and writes through a simple register port with byte strobes.

A pending flag is set by its line and cleared by software writing a one to it. The combined output is a level. It stays high while any line is both pending and enabled. The other fields of the word (error-source masks, request-priority flags and a ready-wait count) are plain read/write storage for neighbouring logic. Reserved bits always read as zero.

An interrupt service routine reads the word, services the pending lines, and acknowledges them by writing ones back. It writes zeros to the flags of lines it has not handled.

Top module: `intx_status_agg`

## Requirements
- R1: After reset, rd_data reads 0x00000000 and irq_out is low.
- R2: A line held high on a clock edge makes its pending flag read 1 after that edge. Line A maps to bit 28, B to bit 29, C to bit 30 and D to bit 31.
- R3: Writing a 1 to a pending flag while its line is low clears it after the edge. Writing a 0 to a pending flag leaves it unchanged.
- R4: When a clear and a high line fall on the same edge, the flag stays pending, because setting wins over clearing.
- R5: The enables sit at bits 22 (A) to 25 (D), and a 1 enables the line. irq_out is high exactly while some line is both pending and enabled.
- R6: Pending flags latch whatever the enable is. Enabling a line that is already pending raises irq_out right after the write edge.
- R7: Bits 27, 26, 21..16, 14..8 and 3..0 are storage that reads back what was last written to it.
- R8: Bits 15 and 7..4 always read 0, and writes to them have no effect.
- R9: On a write, wr_strb[k] allows writes to bits 8k+7..8k and no others. A halfword write of 0xF000 to the upper half (wr_strb=4'b1100, wr_data=0xF0000000) clears all four pending flags, disables all four lines, and zeros the upper storage bits.
- R10: With wr_en low, wr_data and wr_strb change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 4 | Level interrupt lines; bit 0 is line A |
| wr_en | input | 1 | Write strobe for the control word |
| wr_strb | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with its default parameters: four lines, a 32-bit word, pending flags at bits 31..28 and enables at bits 25..22. With these values the lane strobes split the enable field between two bytes, so a write to a single byte changes only half of the enables. This split is what the partial-strobe cases exercise. The bench also covers a clear that meets a still-high line on the same edge, enabling a line that is already pending, and a run of mixed random traffic checked against a reference model built from the requirements.

// File: rtl/intx_pkg.sv
package intx_pkg;
    localparam int NUM_LINES_DEF = 4;
    localparam int REG_W_DEF     = 32;
    localparam int STS_LSB_DEF   = 28;
    localparam int EN_LSB_DEF    = 22;
    // storage bits: 27,26, 21..16, 14..8, 3..0
    localparam logic [31:0] KEEP_MASK_DEF = 32'h0C3F_7F0F;

    typedef struct packed {
        logic sts;
        logic en;
    } line_state_t;
endpackage

// File: rtl/intx_lane_mask.sv
module intx_lane_mask #(
    parameter int REG_W  = 32,
    localparam int STRB_W = REG_W / 8
) (
    input  logic              wr_en,
    input  logic [STRB_W-1:0] wr_strb,
    output logic [REG_W-1:0]  bit_we
);
    for (genvar k = 0; k < STRB_W; k++) begin : g_lane
        assign bit_we[8*k +: 8] = {8{wr_en & wr_strb[k]}};
    end
endmodule

// File: rtl/intx_line_cell.sv
module intx_line_cell
    import intx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic sts_we,
    input  logic sts_wd,
    input  logic en_we,
    input  logic en_wd,
    output logic sts_q,
    output logic en_q
);
    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sts_we && sts_wd) begin
            st_d.sts = 1'b0;
        end
        // a live level re-pends on the same edge
        if (line_in) begin
            st_d.sts = 1'b1;
        end
        if (en_we) begin
            st_d.en = en_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_q = st_q.sts;
    assign en_q  = st_q.en;
endmodule

// File: rtl/intx_field_store.sv
module intx_field_store #(
    parameter int               REG_W     = 32,
    parameter logic [REG_W-1:0] KEEP_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] bit_we,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] fields_q
);
    typedef struct packed {
        logic [REG_W-1:0] bits;
    } store_t;

    store_t fs_d, fs_q;
    logic [REG_W-1:0] upd_mask;

    always_comb begin
        upd_mask    = bit_we & KEEP_MASK;
        fs_d        = fs_q;
        fs_d.bits   = (fs_q.bits & ~upd_mask) | (wr_data & upd_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign fields_q = fs_q.bits;
endmodule

// File: rtl/intx_status_agg.sv
module intx_status_agg
    import intx_pkg::*;
#(
    parameter int               NUM_LINES = NUM_LINES_DEF,
    parameter int               REG_W     = REG_W_DEF,
    parameter int               STS_LSB   = STS_LSB_DEF,
    parameter int               EN_LSB    = EN_LSB_DEF,
    parameter logic [REG_W-1:0] KEEP_MASK = KEEP_MASK_DEF,
    localparam int              STRB_W    = REG_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 wr_en,
    input  logic [STRB_W-1:0]    wr_strb,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq_out
);
    logic [REG_W-1:0]     bit_we;
    logic [REG_W-1:0]     fields_q;
    logic [NUM_LINES-1:0] sts_vec;
    logic [NUM_LINES-1:0] en_vec;

    intx_lane_mask #(.REG_W(REG_W)) u_lane (
        .wr_en  (wr_en),
        .wr_strb(wr_strb),
        .bit_we (bit_we)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        intx_line_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_in(line_in[i]),
            .sts_we (bit_we[STS_LSB+i]),
            .sts_wd (wr_data[STS_LSB+i]),
            .en_we  (bit_we[EN_LSB+i]),
            .en_wd  (wr_data[EN_LSB+i]),
            .sts_q  (sts_vec[i]),
            .en_q   (en_vec[i])
        );
    end

    intx_field_store #(.REG_W(REG_W), .KEEP_MASK(KEEP_MASK)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_we  (bit_we),
        .wr_data (wr_data),
        .fields_q(fields_q)
    );

    always_comb begin
        rd_data = fields_q;
        rd_data[STS_LSB +: NUM_LINES] = sts_vec;
        rd_data[EN_LSB  +: NUM_LINES] = en_vec;
    end

    assign irq_out = |(sts_vec & en_vec);
endmodule

// File: rtl/intx_status_agg_chk.sv
module intx_status_agg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  line_in,
    input logic        wr_en,
    input logic        strb_hi,
    input logic [3:0]  wd_sts,
    input logic [31:0] rd_data,
    input logic        irq_out
);
    // R2: a high line is pending after the edge
    assert_line_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data[31:28] & $past(line_in)) == $past(line_in)));

    // R3: a written 1 with a low line clears the flag
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && strb_hi) |=> ((rd_data[31:28] & $past(wd_sts & ~line_in)) == 4'b0000));

    // R6: flags never drop without a top-byte write
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && strb_hi) |=>
            ((rd_data[31:28] & $past(rd_data[31:28])) == $past(rd_data[31:28])));

    // R10: no write, enables and storage hold
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_data[27:0] == $past(rd_data[27:0])));

    // R5: output level follows pending-and-enabled
    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(rd_data[31:28] & rd_data[25:22])));
endmodule

bind intx_status_agg intx_status_agg_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(line_in),
    .wr_en  (wr_en),
    .strb_hi(wr_strb[3]),
    .wd_sts (wr_data[31:28]),
    .rd_data(rd_data),
    .irq_out(irq_out)
);

// File: tb/intx_status_agg_bench.sv
module intx_status_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  line_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    // reference state from the requirements
    logic [3:0]  m_sts = '0;
    logic [3:0]  m_en  = '0;
    logic [31:0] m_fld = '0;
    localparam logic [31:0] STORE_BITS = 32'h0C3F_7F0F;

    always #10 clk = ~clk;

    intx_status_agg u_intx_status_agg (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = m_fld;
        w[31:28] = m_sts;
        w[25:22] = m_en;
        return w;
    endfunction

    task automatic op(input logic [3:0] ln, input logic we, input logic [3:0] sb,
                      input logic [31:0] wd, input string req);
        logic [31:0] bm;
        exp_t e;
        @(negedge clk);
        line_in = ln; wr_en = we; wr_strb = sb; wr_data = wd;
        bm = {{8{sb[3]}}, {8{sb[2]}}, {8{sb[1]}}, {8{sb[0]}}} & {32{we}};
        m_sts = (m_sts & ~(wd[31:28] & bm[31:28])) | ln;
        m_en  = (m_en & ~bm[25:22]) | (wd[25:22] & bm[25:22]);
        m_fld = (m_fld & ~(bm & STORE_BITS)) | (wd & bm & STORE_BITS);
        @(posedge clk);
        #1;
        e.rd = model_word();
        e.irq = |(m_sts & m_en);
        e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compare at the falling edge after each result
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_data !== e.rd || irq_out !== e.irq) begin
                failures++;
                $display("FAIL %s: rd_data=%08h irq=%b expected rd_data=%08h irq=%b",
                         e.req, rd_data, irq_out, e.rd, e.irq);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        op(4'b0000, 0, 4'h0, 32'h0, "R1 reset state");
        op(4'b0001, 0, 4'h0, 32'h0, "R2 line A sets bit 28");
        op(4'b0100, 0, 4'h0, 32'h0, "R2 line C sets bit 30, A latched");
        op(4'b0000, 0, 4'h0, 32'h0, "R6 pending while disabled, irq low");
        op(4'b0000, 1, 4'hF, 32'h0C3F_FFFF, "R7 R8 storage write, reserved ignored");
        op(4'b0000, 1, 4'h4, 32'h00C0_0000, "R6 enable pending A raises irq");
        op(4'b0000, 1, 4'h1, 32'h0000_0000, "R9 byte 0 only written");
        op(4'b0000, 1, 4'h8, 32'h1000_0000, "R3 clear A, keep C");
        op(4'b0000, 0, 4'h0, 32'h0, "R5 C pending but disabled, irq low");
        op(4'b0010, 0, 4'h0, 32'h0, "R5 B pending and enabled, irq high");
        op(4'b0010, 1, 4'h8, 32'h2000_0000, "R4 clear while B line high stays pending");
        op(4'b0000, 1, 4'h8, 32'h0000_0000, "R3 writing zeros keeps flags");
        op(4'b0000, 0, 4'hF, 32'hFFFF_FFFF, "R10 no wr_en, no change");
        op(4'b1000, 1, 4'h2, 32'h0000_FF00, "R9 byte 1 only, D line sets");
        op(4'b0000, 1, 4'hF, 32'h03C0_0000, "R5 enable all lines");
        op(4'b0000, 1, 4'hC, 32'hF000_0000, "R9 upper halfword F000 clears and disables");
        for (int n = 0; n < 60; n++) begin
            op(4'($urandom), 1'($urandom), 4'($urandom), $urandom, "R5 mixed traffic");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule